// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Timer

This block guards a processor against lost program control. A down-counter decrements once per clock. If software lets it reach zero, the block raises a reset request for a fixed number of cycles and records the event in a sticky overflow flag. After that the counter restarts from the programmed reload value.

Software keeps the counter alive with a two-write sequence on a small register port. The first write sets an arm bit. The very next write must set a refresh bit. A valid refresh loads the counter's upper part from a 7-bit reload register and clears everything below it. Any other write in between cancels the arm, so a single stray write cannot keep a runaway program alive. A status output shows the refresh bit, which the hardware drops a fixed number of clocks after software sets it.

Top module: `arm_refresh_wdt`

## Requirements
- R1: On reset, `wdCount` equals the reset reload value (default 4) placed in bits [14:8] with all other bits zero, so 16'h0400. `rstReq`, `ovfFlag` and `refBusy` are 0.
- R2: Outside a reset request, with no valid refresh and a nonzero count, `wdCount` decreases by exactly one on every clock.
- R3: A control write (`wrAddr`=0) sets the arm bit with bit 0 set and bit 1 clear. If the next write of any kind is a control write with bit 1 set, it is a valid refresh. On that edge `wdCount` becomes {1'b0, reload[6:0], 8'h00}.
- R4: Any write between the arm write and the refresh write cancels the arm. This includes a reload write and a control write without bit 1. A refresh write without a live arm leaves the count decrementing.
- R5: A control write with bit 1 set drives `refBusy` high from the next clock, and `refBusy` stays high for exactly 12 cycles unless rewritten.
- R6: A write with `wrAddr`=1 stores `wrData[6:0]` as the reload value. It does not change the running count. It is used at the next refresh or release.
- R7: On the edge after `wdCount` reads zero with no refresh, `rstReq` goes high and stays high for exactly 24 cycles. `wdCount` holds zero during that time, and refresh sequences are ignored.
- R8: On the edge where `rstReq` falls, `wdCount` becomes {1'b0, reload[6:0], 8'h00} from the current reload value.
- R9: `ovfFlag` sets on the same edge that `rstReq` rises. It stays set through the reset request and afterwards. It is cleared only by a control write with bit 2 set, and a set on the same edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 = control (bit0 arm, bit1 refresh, bit2 clear overflow), 1 = reload value |
| wrData | input | 7 | Write data |
| rstReq | output | 1 | Processor reset request |
| ovfFlag | output | 1 | Sticky overflow flag |
| refBusy | output | 1 | Refresh bit as seen by software |
| wdCount | output | 16 | Current watchdog count |

## Verification
The bench uses the default parameters: a 16-bit counter, a 7-bit reload value, a 12-cycle refresh-bit clear and a 24-cycle reset hold. Because the counter steps every clock, the reset value reaches its first expiry after 1024 cycles. The random phase writes reload values of at most 3, so expiries, holds and releases recur every few hundred cycles. Directed sequences cover three cases: an interrupted arm, a refresh attempted during the hold, and a reload value changed while the reset request is active.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ARM_BIT = 0;
  localparam int REF_BIT = 1;
  localparam int CLR_BIT = 2;

  typedef struct packed {
    logic load;
    logic dec;
    logic setOvf;
    logic clrOvf;
    logic wrRel;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CLR_DLY  = 12,
  parameter int RST_HOLD = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        wrAddr,
  input  logic [2:0]  ctlBits,
  input  logic        cntZero,
  output wdt_strobe_t stb,
  output logic        rstReq,
  output logic        refBusy
);
  localparam int RC_W = $clog2(CLR_DLY + 1);
  localparam int HC_W = $clog2(RST_HOLD + 1);

  logic            armed;
  logic [RC_W-1:0] refCnt;
  logic [HC_W-1:0] holdCnt;
  logic            ctrlWr, refWr, doRefresh, expire, release_w;

  assign ctrlWr    = wrEn && !wrAddr;
  assign refWr     = ctrlWr && ctlBits[REF_BIT];
  assign doRefresh = refWr && armed && !rstReq;
  assign expire    = !rstReq && cntZero && !doRefresh;
  assign release_w = rstReq && (holdCnt == HC_W'(1));

  always_comb begin
    stb.load   = doRefresh || release_w;
    stb.dec    = !rstReq && !cntZero && !doRefresh;
    stb.setOvf = expire;
    stb.clrOvf = ctrlWr && ctlBits[CLR_BIT];
    stb.wrRel  = wrEn && wrAddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (wrEn) armed <= ctrlWr && ctlBits[ARM_BIT] && !ctlBits[REF_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refCnt <= '0;
    else if (refWr) refCnt <= RC_W'(CLR_DLY);
    else if (refCnt != '0) refCnt <= refCnt - RC_W'(1);
  end
  assign refBusy = (refCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstReq  <= 1'b0;
      holdCnt <= '0;
    end else if (expire) begin
      rstReq  <= 1'b1;
      holdCnt <= HC_W'(RST_HOLD);
    end else if (release_w) begin
      rstReq  <= 1'b0;
      holdCnt <= '0;
    end else if (rstReq) begin
      holdCnt <= holdCnt - HC_W'(1);
    end
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int             CNT_W   = 16,
  parameter int             REL_W   = 7,
  parameter logic [REL_W-1:0] RST_REL = 7'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wdt_strobe_t       stb,
  input  logic [REL_W-1:0]  relData,
  output logic [CNT_W-1:0]  wdCount,
  output logic [REL_W-1:0]  relVal,
  output logic              ovfFlag,
  output logic              cntZero
);
  localparam int LOW_W = CNT_W - REL_W - 1;
  localparam logic [CNT_W-1:0] RST_CNT = {1'b0, RST_REL, {LOW_W{1'b0}}};

  logic [CNT_W-1:0] loadVal;
  assign loadVal = {1'b0, relVal, {LOW_W{1'b0}}};
  assign cntZero = (wdCount == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdCount <= RST_CNT;
    else if (stb.load) wdCount <= loadVal;
    else if (stb.dec) wdCount <= wdCount - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) relVal <= RST_REL;
    else if (stb.wrRel) relVal <= relData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovfFlag <= 1'b0;
    else if (stb.setOvf) ovfFlag <= 1'b1;
    else if (stb.clrOvf) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/arm_refresh_wdt.sv
module arm_refresh_wdt
  import wdt_pkg::*;
#(
  parameter int               CNT_W    = 16,
  parameter int               REL_W    = 7,
  parameter logic [REL_W-1:0] RST_REL  = 7'd4,
  parameter int               CLR_DLY  = 12,
  parameter int               RST_HOLD = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [REL_W-1:0] wrData,
  output logic             rstReq,
  output logic             ovfFlag,
  output logic             refBusy,
  output logic [CNT_W-1:0] wdCount
);
  wdt_strobe_t      stb;
  logic             cntZero;
  logic [REL_W-1:0] relVal;

  wdt_ctrl #(.CLR_DLY(CLR_DLY), .RST_HOLD(RST_HOLD)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .ctlBits(wrData[2:0]), .cntZero(cntZero), .stb(stb),
    .rstReq(rstReq), .refBusy(refBusy)
  );

  wdt_datapath #(.CNT_W(CNT_W), .REL_W(REL_W), .RST_REL(RST_REL)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .relData(wrData),
    .wdCount(wdCount), .relVal(relVal), .ovfFlag(ovfFlag), .cntZero(cntZero)
  );
endmodule

// File: rtl/arm_refresh_wdt_chk.sv
module arm_refresh_wdt_chk #(
  parameter int CNT_W = 16,
  parameter int REL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrEn,
  input logic             wrAddr,
  input logic [REL_W-1:0] wrData,
  input logic             rstReq,
  input logic             ovfFlag,
  input logic             refBusy,
  input logic [CNT_W-1:0] wdCount,
  input logic [REL_W-1:0] relVal
);
  localparam int LOW_W = CNT_W - REL_W - 1;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rstReq && wdCount != '0 && !(wrEn && !wrAddr)) |=> (wdCount == $past(wdCount) - CNT_W'(1)));

  // R7
  expire_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstReq) |-> ($past(wdCount) == '0));

  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rstReq && $past(rstReq)) |-> (wdCount == '0));

  // R8
  release_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rstReq) |-> (wdCount == {1'b0, $past(relVal), {LOW_W{1'b0}}}));

  // R9
  ovf_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstReq) |-> ovfFlag);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !(wrEn && !wrAddr && wrData[2])) |=> ovfFlag);

  // R5
  ref_busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refBusy) |-> $past(wrEn && !wrAddr && wrData[1]));
endmodule

bind arm_refresh_wdt arm_refresh_wdt_chk #(.CNT_W(CNT_W), .REL_W(REL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rstReq(rstReq), .ovfFlag(ovfFlag), .refBusy(refBusy), .wdCount(wdCount),
  .relVal(relVal)
);

// File: tb/arm_refresh_wdt_tb_top.sv
module arm_refresh_wdt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [6:0]  wrData = '0;
  logic        rstReq, ovfFlag, refBusy;
  logic [15:0] wdCount;

  int checks = 0;
  int fails = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  arm_refresh_wdt dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rstReq(rstReq), .ovfFlag(ovfFlag), .refBusy(refBusy), .wdCount(wdCount)
  );

  // reference model built from the requirements
  logic [15:0] mCnt;
  logic [6:0]  mRel;
  logic        mOvf, mArmed, mRst;
  int          mHold, mRef;

  function automatic logic [15:0] relToCnt(input logic [6:0] r);
    return {1'b0, r, 8'h00};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCnt = relToCnt(7'd4); mRel = 7'd4; mOvf = 0; mArmed = 0;
      mRst = 0; mHold = 0; mRef = 0;
    end else begin
      bit ctrlW, refW, valid;
      ctrlW = wrEn && !wrAddr;
      refW  = ctrlW && wrData[1];
      valid = refW && mArmed && !mRst;
      if (ctrlW && wrData[2]) mOvf = 0;
      if (mRst) begin
        if (mHold == 1) begin mRst = 0; mCnt = relToCnt(mRel); end
        else mHold = mHold - 1;
      end else if (valid) mCnt = relToCnt(mRel);
      else if (mCnt == 0) begin mRst = 1; mHold = 24; mOvf = 1; end
      else mCnt = mCnt - 1;
      if (wrEn && wrAddr) mRel = wrData;
      if (wrEn) mArmed = ctrlW && wrData[0] && !wrData[1];
      if (refW) mRef = 12; else if (mRef != 0) mRef = mRef - 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && !done) begin
      chk("R2 count", 32'(wdCount), 32'(mCnt));
      chk("R7 rstReq", 32'(rstReq), 32'(mRst));
      chk("R9 ovfFlag", 32'(ovfFlag), 32'(mOvf));
      chk("R5 refBusy", 32'(refBusy), 32'(mRef != 0));
    end
  end

  task automatic wr(input logic a, input logic [6:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired before completion");
    finishRun();
  end

  initial begin
    logic [15:0] c;
    int hi;
    int seedDummy;
    seedDummy = $urandom(32'h1d2e3f);
    idle(2);
    // R1 reset state
    chk("R1 count", 32'(wdCount), 32'h0400);
    chk("R1 rstReq", 32'(rstReq), 0);
    chk("R1 ovfFlag", 32'(ovfFlag), 0);
    chk("R1 refBusy", 32'(refBusy), 0);
    rst_n = 1'b1;
    cmpOn = 1'b1;
    idle(1);
    chk("R2 first step", 32'(wdCount), 32'h03FF);

    // R6 reload write alone leaves the count running
    c = wdCount;
    wr(1'b1, 7'd5);
    chk("R6 no count change", 32'(wdCount), 32'(c - 16'd1));

    // R3 valid two-step refresh
    wr(1'b0, 7'b001);
    wr(1'b0, 7'b010);
    chk("R3 refresh load", 32'(wdCount), 32'h0500);
    // R5 refresh bit clears after 12 cycles
    chk("R5 busy first", 32'(refBusy), 1);
    idle(11);
    chk("R5 busy twelfth", 32'(refBusy), 1);
    idle(1);
    chk("R5 busy cleared", 32'(refBusy), 0);

    // R4 reload write between arm and refresh cancels the arm
    wr(1'b0, 7'b001);
    wr(1'b1, 7'd3);
    c = wdCount;
    wr(1'b0, 7'b010);
    chk("R4 reload between", 32'(wdCount), 32'(c - 16'd1));
    // R4 plain control write between cancels too
    wr(1'b0, 7'b001);
    wr(1'b0, 7'b000);
    c = wdCount;
    wr(1'b0, 7'b010);
    chk("R4 ctrl between", 32'(wdCount), 32'(c - 16'd1));
    // R4 refresh with no arm at all
    c = wdCount;
    wr(1'b0, 7'b010);
    chk("R4 no arm", 32'(wdCount), 32'(c - 16'd1));

    // R7 / R8 / R9 expiry path
    wr(1'b1, 7'd0);
    wr(1'b0, 7'b001);
    wr(1'b0, 7'b010);
    chk("R3 load zero", 32'(wdCount), 0);
    wr(1'b1, 7'd2);
    chk("R7 request high", 32'(rstReq), 1);
    chk("R9 flag set", 32'(ovfFlag), 1);
    hi = 1;
    wr(1'b0, 7'b001);
    wr(1'b0, 7'b010);
    hi += 2;
    chk("R7 refresh ignored", 32'(wdCount), 0);
    while (rstReq && hi < 100) begin
      idle(1);
      if (rstReq) hi++;
    end
    chk("R7 hold length", 32'(hi), 24);
    chk("R8 release load", 32'(wdCount), 32'h0200);
    chk("R9 flag sticky", 32'(ovfFlag), 1);
    wr(1'b0, 7'b100);
    chk("R9 flag cleared", 32'(ovfFlag), 0);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 8000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) begin
        wr(1'b0, 7'b001);
        wr(1'b0, 7'b010);
      end else if (r == 1) wr(1'b1, 7'($urandom % 4));
      else if (r == 2) wr(1'b0, 7'($urandom % 8));
      else if (r == 3) wr(1'b0, 7'b010);
      else idle(1);
    end
    finishRun();
  end
endmodule